// File: doc/BRIEF.md
# Histogram Engine Control and Status Register Bank

This block is the host-facing register bank of a video histogram engine. It sits on a simple 32-bit read/write bus: address, write data, write enable, read enable, and read data that comes back with a read-valid one cycle after the read enable. It holds a set of fixed parameter words that describe how the engine was built, and a frame-size pair that takes effect as soon as it is written. It also holds four region-of-interest positions that are written into a staging copy and reach the engine only after a commit.

A commit is a write of any value to the commit word. It marks the staged values as pending. The engine's start-of-frame strobe then copies them into the active copies on a frame boundary, and the block pulses a commit strobe for one cycle at that point. The freeze request bit in the control word is not staged. It drives a four-phase handshake with the engine: the frozen flag drops, a sample request is held to the engine until the engine reports a fresh sample, the flag rises again, and the host must drop the request before it asks for a new sample.

Reads in the statistics window are passed on to the engine's two bin memories, one for the whole frame and one for the region of interest. Each of those memories returns data one cycle after its read enable.

Top module: `hist_csr_bank`

## Requirements
- R1: Offset 0x000 reads 0x6FA7017B. Offsets 0x004 through 0x02C read, in steps of 4: version, lite flag (always 1), debug flag, bits per symbol in, bits per symbol out, colour planes in, colour planes out, pixels in parallel, maximum width, maximum height, bin count.
- R2: `bus_rvalid` is high exactly in the cycle after a cycle with `bus_re` high, and `bus_rdata` holds the read result in that cycle.
- R3: The frame width word (0x120), the frame height word (0x124) and the four ROI words keep only bits 15:0, and bits 31:16 read as zero. A write to the width or height word appears on `frame_w`/`frame_h` in the following cycle.
- R4: The ROI words are horizontal start (0x150), vertical start (0x154), horizontal end (0x158) and vertical end (0x15C). A read returns the staged value. Writing them does not change `roi_x0`, `roi_y0`, `roi_x1` or `roi_y1`.
- R5: A write of any value to 0x148 sets the pending flag (status bit 1). While that flag is set, the next cycle with `eng_sof` high copies the staged ROI values to the outputs and clears the flag. `commit_pulse` is high for the single cycle after that. A start of frame with no commit pending changes nothing.
- R6: Bit 31 of the control word (0x14C) is the freeze request, and bits 30:0 read as zero. When the request rises, the frozen flag (status bit 2, `stats_frozen`) clears and `sample_req` is raised. On `eng_sample_done`, `sample_req` falls and the frozen flag sets. The flag stays set, and no new sample starts, until the request has been dropped and raised again.
- R7: The freeze handshake proceeds while a commit is pending.
- R8: Status bit 0 reads the value of `eng_busy`.
- R9: A read at 0x200 + 4k (k < bin count) returns `frame_bin_data` for bin k. A read at 0x200 + 4·bins + 4k returns `roi_bin_data` for bin k. `bin_idx` carries k, with `frame_bin_rd` or `roi_bin_rd` strobed in the read cycle.
- R10: Offset 0x144 reads `eng_checksum` in bits 7:0, and the other bits read as zero.
- R11: Reads of reserved addresses (including offsets at or above the end of the ROI bin window) return zero. Writes to read-only, reserved or bin addresses change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_re |
| eng_busy | input | 1 | Engine is processing data |
| eng_sof | input | 1 | Start-of-frame strobe from the engine |
| eng_sample_done | input | 1 | Engine finished a fresh statistics sample |
| eng_checksum | input | 8 | Frame checksum from the engine |
| bin_idx | output | log2(BINS) | Bin index for a statistics read |
| frame_bin_rd | output | 1 | Read strobe to the whole-frame bin memory |
| roi_bin_rd | output | 1 | Read strobe to the ROI bin memory |
| frame_bin_data | input | 32 | Whole-frame bin data, one cycle after strobe |
| roi_bin_data | input | 32 | ROI bin data, one cycle after strobe |
| frame_w | output | 16 | Frame width |
| frame_h | output | 16 | Frame height |
| roi_x0 | output | 16 | Active ROI horizontal start |
| roi_y0 | output | 16 | Active ROI vertical start |
| roi_x1 | output | 16 | Active ROI horizontal end |
| roi_y1 | output | 16 | Active ROI vertical end |
| sample_req | output | 1 | Request to the engine for a fresh sample |
| stats_frozen | output | 1 | Statistics are frozen |
| commit_pulse | output | 1 | One-cycle strobe when staged ROI values are applied |

## Verification
The assertions take for granted that the engine keeps its side of the handshake: `eng_sample_done` is pulsed only while `sample_req` is high. They also assume that the bin memories answer exactly one cycle after their strobe. The bench's engine model registers its bin data on the strobe and pulses the done input only after it has seen `sample_req` high. The host side follows the freeze protocol: it holds the request until the flag sets and drops it before asking again. All bus accesses are word aligned and never assert read and write in the same cycle.

// File: rtl/hist_csr_pkg.sv
package hist_csr_pkg;
  // parameter words
  localparam logic [15:0] A_ID      = 16'h0000;
  localparam logic [15:0] A_VER     = 16'h0004;
  localparam logic [15:0] A_LITE    = 16'h0008;
  localparam logic [15:0] A_DBG     = 16'h000C;
  localparam logic [15:0] A_BPS_I   = 16'h0010;
  localparam logic [15:0] A_BPS_O   = 16'h0014;
  localparam logic [15:0] A_COL_I   = 16'h0018;
  localparam logic [15:0] A_COL_O   = 16'h001C;
  localparam logic [15:0] A_PIP     = 16'h0020;
  localparam logic [15:0] A_MAXW    = 16'h0024;
  localparam logic [15:0] A_MAXH    = 16'h0028;
  localparam logic [15:0] A_NBIN    = 16'h002C;
  // control and status words
  localparam logic [15:0] A_WIDTH   = 16'h0120;
  localparam logic [15:0] A_HEIGHT  = 16'h0124;
  localparam logic [15:0] A_STATUS  = 16'h0140;
  localparam logic [15:0] A_FSTAT   = 16'h0144;
  localparam logic [15:0] A_COMMIT  = 16'h0148;
  localparam logic [15:0] A_CTRL    = 16'h014C;
  localparam logic [15:0] A_ROI0    = 16'h0150;  // x0, y0, x1, y1 in consecutive words
  localparam int          NUM_ROI   = 4;
  localparam logic [15:0] A_BIN0    = 16'h0200;

  localparam logic [31:0] ID_WORD   = 32'h6FA7_017B;

  localparam int ST_RUN    = 0;
  localparam int ST_PEND   = 1;
  localparam int ST_FROZEN = 2;
  localparam int CTRL_FRZ  = 31;

  typedef enum logic [1:0] {
    FZ_IDLE   = 2'd0,
    FZ_SAMPLE = 2'd1,
    FZ_HOLD   = 2'd2
  } fz_state_t;
endpackage

// File: rtl/hist_csr_params.sv
module hist_csr_params #(
  parameter int VERSION  = 32'h0001_0000,
  parameter int DEBUG_EN = 1,
  parameter int BPS      = 10,
  parameter int NCOL     = 3,
  parameter int PIP      = 1,
  parameter int MAX_W    = 1920,
  parameter int MAX_H    = 1080,
  parameter int BINS     = 64
) (
  input  logic [15:0] addr,
  output logic        hit,
  output logic [31:0] data
);
  import hist_csr_pkg::*;

  always_comb begin
    hit  = 1'b1;
    data = '0;
    case (addr)
      A_ID:    data = ID_WORD;
      A_VER:   data = 32'(VERSION);
      A_LITE:  data = 32'd1;
      A_DBG:   data = 32'(DEBUG_EN != 0);
      A_BPS_I: data = 32'(BPS);
      A_BPS_O: data = 32'(BPS);
      A_COL_I: data = 32'(NCOL);
      A_COL_O: data = 32'(NCOL);
      A_PIP:   data = 32'(PIP);
      A_MAXW:  data = 32'(MAX_W);
      A_MAXH:  data = 32'(MAX_H);
      A_NBIN:  data = 32'(BINS);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/hist_csr_stage.sv
module hist_csr_stage #(
  parameter int POS_W = 16,
  parameter int N     = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N-1:0]             wr_sel,
  input  logic [POS_W-1:0]         wr_val,
  input  logic                     commit_wr,
  input  logic                     sof,
  output logic [N-1:0][POS_W-1:0]  staged,
  output logic [N-1:0][POS_W-1:0]  active,
  output logic                     pending,
  output logic                     applied
);
  logic apply;
  assign apply = pending & sof;

  always_ff @(posedge clk) begin
    if (rst) begin
      staged <= '0;
      active <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wr_sel[i]) staged[i] <= wr_val;
        if (apply)     active[i] <= staged[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      applied <= 1'b0;
    end else begin
      pending <= commit_wr | (pending & ~sof);
      applied <= apply;
    end
  end
endmodule

// File: rtl/hist_csr_freeze.sv
module hist_csr_freeze (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic done,
  output logic sample_req,
  output logic frozen
);
  import hist_csr_pkg::*;

  fz_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= FZ_IDLE;
      frozen <= 1'b0;
    end else begin
      case (st)
        FZ_IDLE: if (req) begin
          st     <= FZ_SAMPLE;
          frozen <= 1'b0;
        end
        FZ_SAMPLE: if (done) begin
          st     <= FZ_HOLD;
          frozen <= 1'b1;
        end
        FZ_HOLD: if (!req) st <= FZ_IDLE;
        default: st <= FZ_IDLE;
      endcase
    end
  end

  assign sample_req = (st == FZ_SAMPLE);
endmodule

// File: rtl/hist_csr_bank.sv
module hist_csr_bank #(
  parameter int ADDR_W   = 12,
  parameter int BINS     = 64,
  parameter int VERSION  = 32'h0001_0000,
  parameter int DEBUG_EN = 1,
  parameter int BPS      = 10,
  parameter int NCOL     = 3,
  parameter int PIP      = 1,
  parameter int MAX_W    = 1920,
  parameter int MAX_H    = 1080
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  input  logic                     bus_we,
  input  logic                     bus_re,
  output logic [31:0]              bus_rdata,
  output logic                     bus_rvalid,
  input  logic                     eng_busy,
  input  logic                     eng_sof,
  input  logic                     eng_sample_done,
  input  logic [7:0]               eng_checksum,
  output logic [$clog2(BINS)-1:0]  bin_idx,
  output logic                     frame_bin_rd,
  output logic                     roi_bin_rd,
  input  logic [31:0]              frame_bin_data,
  input  logic [31:0]              roi_bin_data,
  output logic [15:0]              frame_w,
  output logic [15:0]              frame_h,
  output logic [15:0]              roi_x0,
  output logic [15:0]              roi_y0,
  output logic [15:0]              roi_x1,
  output logic [15:0]              roi_y1,
  output logic                     sample_req,
  output logic                     stats_frozen,
  output logic                     commit_pulse
);
  import hist_csr_pkg::*;

  localparam int          BIN_W   = $clog2(BINS);
  localparam int          POS_W   = 16;
  localparam logic [15:0] WIN_SPAN = 16'(4 * BINS);
  localparam logic [15:0] FRM_LO  = A_BIN0;
  localparam logic [15:0] ROI_LO  = A_BIN0 + WIN_SPAN;
  localparam logic [15:0] ROI_HI  = ROI_LO + WIN_SPAN;

  logic [15:0] a16;
  assign a16 = 16'(bus_addr);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[30:16];

  // ---------------- write decode ----------------
  logic [NUM_ROI-1:0] roi_wr;
  for (genvar g = 0; g < NUM_ROI; g++) begin : g_roi_dec
    assign roi_wr[g] = bus_we && (a16 == A_ROI0 + 16'(4 * g));
  end

  logic commit_wr;
  assign commit_wr = bus_we && (a16 == A_COMMIT);

  // ---------------- immediate registers ----------------
  logic freeze_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_w  <= '0;
      frame_h  <= '0;
      freeze_q <= 1'b0;
    end else if (bus_we) begin
      if (a16 == A_WIDTH)  frame_w  <= bus_wdata[POS_W-1:0];
      if (a16 == A_HEIGHT) frame_h  <= bus_wdata[POS_W-1:0];
      if (a16 == A_CTRL)   freeze_q <= bus_wdata[CTRL_FRZ];
    end
  end

  // ---------------- staged ROI ----------------
  logic [NUM_ROI-1:0][POS_W-1:0] roi_stg;
  logic [NUM_ROI-1:0][POS_W-1:0] roi_act;
  logic                          commit_pend;

  hist_csr_stage #(.POS_W(POS_W), .N(NUM_ROI)) i_stage (
    .clk       (clk),
    .rst       (rst),
    .wr_sel    (roi_wr),
    .wr_val    (bus_wdata[POS_W-1:0]),
    .commit_wr (commit_wr),
    .sof       (eng_sof),
    .staged    (roi_stg),
    .active    (roi_act),
    .pending   (commit_pend),
    .applied   (commit_pulse)
  );

  assign roi_x0 = roi_act[0];
  assign roi_y0 = roi_act[1];
  assign roi_x1 = roi_act[2];
  assign roi_y1 = roi_act[3];

  // ---------------- freeze handshake ----------------
  hist_csr_freeze i_freeze (
    .clk        (clk),
    .rst        (rst),
    .req        (freeze_q),
    .done       (eng_sample_done),
    .sample_req (sample_req),
    .frozen     (stats_frozen)
  );

  // ---------------- parameter words ----------------
  logic        par_hit;
  logic [31:0] par_data;

  hist_csr_params #(
    .VERSION (VERSION), .DEBUG_EN(DEBUG_EN), .BPS(BPS), .NCOL(NCOL),
    .PIP     (PIP),     .MAX_W   (MAX_W),    .MAX_H(MAX_H), .BINS(BINS)
  ) i_params (
    .addr (a16),
    .hit  (par_hit),
    .data (par_data)
  );

  // ---------------- statistics window routing ----------------
  logic in_frm, in_roi;
  assign in_frm = (a16 >= FRM_LO) && (a16 < ROI_LO);
  assign in_roi = (a16 >= ROI_LO) && (a16 < ROI_HI);

  logic [15:0] frm_off, roi_off;
  assign frm_off = (a16 - FRM_LO) >> 2;
  assign roi_off = (a16 - ROI_LO) >> 2;

  logic unused_off;
  assign unused_off = ^{frm_off[15:BIN_W], roi_off[15:BIN_W]};

  assign bin_idx      = in_roi ? roi_off[BIN_W-1:0] : frm_off[BIN_W-1:0];
  assign frame_bin_rd = bus_re && in_frm;
  assign roi_bin_rd   = bus_re && in_roi;

  // ---------------- register read mux ----------------
  logic [31:0] csr_rd;
  always_comb begin
    csr_rd = '0;
    if (par_hit) begin
      csr_rd = par_data;
    end else begin
      case (a16)
        A_WIDTH:  csr_rd = {16'd0, frame_w};
        A_HEIGHT: csr_rd = {16'd0, frame_h};
        A_STATUS: begin
          csr_rd[ST_RUN]    = eng_busy;
          csr_rd[ST_PEND]   = commit_pend;
          csr_rd[ST_FROZEN] = stats_frozen;
        end
        A_FSTAT:  csr_rd = {24'd0, eng_checksum};
        A_CTRL:   csr_rd[CTRL_FRZ] = freeze_q;
        default: begin
          for (int i = 0; i < NUM_ROI; i++)
            if (a16 == A_ROI0 + 16'(4 * i)) csr_rd = {16'd0, roi_stg[i]};
        end
      endcase
    end
  end

  logic        rvalid_q, sel_frm_q, sel_roi_q;
  logic [31:0] csr_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q  <= 1'b0;
      sel_frm_q <= 1'b0;
      sel_roi_q <= 1'b0;
      csr_q     <= '0;
    end else begin
      rvalid_q  <= bus_re;
      sel_frm_q <= frame_bin_rd;
      sel_roi_q <= roi_bin_rd;
      if (bus_re) csr_q <= csr_rd;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = sel_frm_q ? frame_bin_data :
                      sel_roi_q ? roi_bin_data   : csr_q;
endmodule

// File: rtl/hist_csr_chk.sv
module hist_csr_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_re,
  input logic        bus_rvalid,
  input logic        frame_bin_rd,
  input logic        roi_bin_rd,
  input logic        eng_sof,
  input logic        commit_pend,
  input logic        commit_pulse,
  input logic [63:0] roi_all,
  input logic        sample_req,
  input logic        stats_frozen
);
  // R2: read data is valid the cycle after a read request
  a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> bus_rvalid);
  a_r2_no_stray_valid: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> !bus_rvalid);
  // R4: active ROI moves only with the commit strobe
  a_r4_roi_hold: assert property (@(posedge clk) disable iff (rst)
    !commit_pulse |-> $stable(roi_all));
  // R5: commit strobe only after a start of frame with a commit pending
  a_r5_pulse_at_sof: assert property (@(posedge clk) disable iff (rst)
    commit_pulse |-> ($past(eng_sof) && $past(commit_pend)));
  a_r5_pend_clear_sof: assert property (@(posedge clk) disable iff (rst)
    $fell(commit_pend) |-> $past(eng_sof));
  // R6: freeze handshake phases
  a_r6_req_unfrozen: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_req) |-> !stats_frozen);
  a_r6_done_frozen: assert property (@(posedge clk) disable iff (rst)
    $fell(sample_req) |-> stats_frozen);
  // R9: at most one bin memory addressed
  a_r9_one_bank: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_bin_rd, roi_bin_rd}));
endmodule

bind hist_csr_bank hist_csr_chk i_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_re       (bus_re),
  .bus_rvalid   (bus_rvalid),
  .frame_bin_rd (frame_bin_rd),
  .roi_bin_rd   (roi_bin_rd),
  .eng_sof      (eng_sof),
  .commit_pend  (commit_pend),
  .commit_pulse (commit_pulse),
  .roi_all      ({roi_x0, roi_y0, roi_x1, roi_y1}),
  .sample_req   (sample_req),
  .stats_frozen (stats_frozen)
);

// File: tb/test_hist_csr_bank.sv
`timescale 1ns/1ps
module test_hist_csr_bank;
  localparam int ADDR_W = 12;
  localparam int BINS   = 64;
  localparam int BIN_W  = $clog2(BINS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic eng_busy = 1'b0, eng_sof = 1'b0, eng_sample_done = 1'b0;
  logic [7:0] eng_checksum = 8'h00;
  logic [BIN_W-1:0] bin_idx;
  logic frame_bin_rd, roi_bin_rd;
  logic [31:0] frame_bin_data, roi_bin_data;
  logic [15:0] frame_w, frame_h, roi_x0, roi_y0, roi_x1, roi_y1;
  logic sample_req, stats_frozen, commit_pulse;

  hist_csr_bank #(.ADDR_W(ADDR_W), .BINS(BINS), .VERSION(32'h0002_0003),
    .DEBUG_EN(1), .BPS(10), .NCOL(3), .PIP(2), .MAX_W(1920), .MAX_H(1080)) i_hist_csr_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .eng_busy(eng_busy), .eng_sof(eng_sof), .eng_sample_done(eng_sample_done),
    .eng_checksum(eng_checksum), .bin_idx(bin_idx), .frame_bin_rd(frame_bin_rd),
    .roi_bin_rd(roi_bin_rd), .frame_bin_data(frame_bin_data), .roi_bin_data(roi_bin_data),
    .frame_w(frame_w), .frame_h(frame_h), .roi_x0(roi_x0), .roi_y0(roi_y0),
    .roi_x1(roi_x1), .roi_y1(roi_y1), .sample_req(sample_req),
    .stats_frozen(stats_frozen), .commit_pulse(commit_pulse));

  // engine bin memory model: one-cycle read latency
  always_ff @(posedge clk) begin
    if (frame_bin_rd) frame_bin_data <= 32'hF000_0000 | 32'(bin_idx);
    if (roi_bin_rd)   roi_bin_data   <= 32'hA000_0000 | 32'(bin_idx);
  end

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (bus_rvalid && exp_q.size() > 0) begin
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(bus_rdata === e, t, bus_rdata, e);
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); exp_q.push_back(e); tag_q.push_back(tag); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0;
    chk(bus_rvalid === 1'b1, "R2 rvalid one cycle after read", 32'(bus_rvalid), 32'd1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sof_pulse();
    @(negedge clk); eng_sof = 1'b1;
    @(negedge clk); eng_sof = 1'b0;
  endtask

  bit finished = 1'b0;

  initial begin
    idle(4);
    @(negedge clk); rst = 1'b0;
    // reset state
    chk(roi_x0 == 0 && roi_y1 == 0, "R4 reset ROI outputs", {roi_x0, roi_y1}, 32'd0);
    chk(!stats_frozen && !sample_req, "R6 reset handshake", {30'd0, stats_frozen, sample_req}, 32'd0);
    chk(!commit_pulse && !bus_rvalid, "R5 reset strobes", {30'd0, commit_pulse, bus_rvalid}, 32'd0);
    @(negedge clk);
    chk(bus_rvalid === 1'b0, "R2 no valid without read", 32'(bus_rvalid), 32'd0);

    // R1 parameter words
    rd(12'h000, 32'h6FA7_017B, "R1 id word");
    rd(12'h004, 32'h0002_0003, "R1 version");
    rd(12'h008, 32'd1, "R1 lite flag");
    rd(12'h00C, 32'd1, "R1 debug flag");
    rd(12'h010, 32'd10, "R1 bps in");
    rd(12'h014, 32'd10, "R1 bps out");
    rd(12'h018, 32'd3, "R1 colours in");
    rd(12'h01C, 32'd3, "R1 colours out");
    rd(12'h020, 32'd2, "R1 pixels in parallel");
    rd(12'h024, 32'd1920, "R1 max width");
    rd(12'h028, 32'd1080, "R1 max height");
    rd(12'h02C, 32'd64, "R1 bin count");

    // R3 immediate frame size
    wr(12'h120, 32'h1234_0780);
    chk(frame_w == 16'h0780, "R3 width applies at once", 32'(frame_w), 32'h780);
    wr(12'h124, 32'hFFFF_0438);
    chk(frame_h == 16'h0438, "R3 height applies at once", 32'(frame_h), 32'h438);
    rd(12'h120, 32'h0000_0780, "R3 width upper bits zero");
    rd(12'h124, 32'h0000_0438, "R3 height upper bits zero");

    // R4 staged ROI
    wr(12'h150, 32'hABCD_000A);
    wr(12'h154, 32'hABCD_0014);
    wr(12'h158, 32'hABCD_0064);
    wr(12'h15C, 32'hABCD_00C8);
    rd(12'h150, 32'h0000_000A, "R4 staged x0 readback (R3 upper zero)");
    rd(12'h15C, 32'h0000_00C8, "R4 staged y1 readback");
    chk(roi_x0 == 0 && roi_y1 == 0, "R4 staged writes not applied", {roi_x0, roi_y1}, 32'd0);

    // R5 start of frame without commit does nothing
    sof_pulse();
    chk(roi_x0 == 0 && !commit_pulse, "R5 sof without commit", {15'd0, commit_pulse, roi_x0}, 32'd0);

    // R5 commit then frame boundary
    wr(12'h148, 32'h0000_0000);
    rd(12'h140, 32'h0000_0002, "R5 pending flag set");
    idle(3);
    chk(roi_x0 == 0, "R5 not applied before sof", 32'(roi_x0), 32'd0);
    @(negedge clk); eng_sof = 1'b1;
    @(negedge clk); eng_sof = 1'b0;
    chk(commit_pulse === 1'b1, "R5 commit strobe", 32'(commit_pulse), 32'd1);
    chk(roi_x0 == 16'd10 && roi_y0 == 16'd20 && roi_x1 == 16'd100 && roi_y1 == 16'd200,
        "R5 ROI applied", {roi_x0, roi_y1}, {16'd10, 16'd200});
    @(negedge clk);
    chk(commit_pulse === 1'b0, "R5 strobe one cycle", 32'(commit_pulse), 32'd0);
    rd(12'h140, 32'h0000_0000, "R5 pending cleared");

    // R8 busy mirror
    eng_busy = 1'b1;
    rd(12'h140, 32'h0000_0001, "R8 running bit");

    // R6/R7 freeze handshake with a commit pending
    wr(12'h150, 32'h0000_0037);
    wr(12'h148, 32'h1111_1111);
    wr(12'h14C, 32'hFFFF_FFFF);
    idle(2);
    chk(sample_req === 1'b1 && stats_frozen === 1'b0, "R7 sample starts while commit pending",
        {30'd0, sample_req, stats_frozen}, 32'd2);
    rd(12'h140, 32'h0000_0003, "R7 status pending not frozen");
    rd(12'h14C, 32'h8000_0000, "R6 control reserved bits zero");
    @(negedge clk); eng_sample_done = 1'b1;
    @(negedge clk); eng_sample_done = 1'b0;
    chk(stats_frozen === 1'b1 && sample_req === 1'b0, "R6 frozen after done",
        {30'd0, sample_req, stats_frozen}, 32'd1);
    rd(12'h140, 32'h0000_0007, "R6 status frozen");
    idle(5);
    chk(stats_frozen === 1'b1 && sample_req === 1'b0, "R6 holds while request high",
        {30'd0, sample_req, stats_frozen}, 32'd1);
    chk(roi_x0 == 16'd10, "R4 staged x0 still inactive", 32'(roi_x0), 32'd10);
    sof_pulse();
    chk(roi_x0 == 16'h37, "R5 second commit applied", 32'(roi_x0), 32'h37);
    wr(12'h14C, 32'h0000_0000);
    idle(2);
    chk(stats_frozen === 1'b1, "R6 flag kept after drop", 32'(stats_frozen), 32'd1);
    wr(12'h14C, 32'h8000_0000);
    idle(2);
    chk(stats_frozen === 1'b0 && sample_req === 1'b1, "R6 new request lowers flag",
        {30'd0, sample_req, stats_frozen}, 32'd2);
    @(negedge clk); eng_sample_done = 1'b1;
    @(negedge clk); eng_sample_done = 1'b0;
    wr(12'h14C, 32'h0000_0000);
    rd(12'h140, 32'h0000_0005, "R6 second sample frozen");

    // R9 bin windows
    rd(12'h200, 32'hF000_0000, "R9 frame bin 0");
    rd(12'h214, 32'hF000_0005, "R9 frame bin 5");
    rd(12'h2FC, 32'hF000_003F, "R9 frame bin 63");
    rd(12'h300, 32'hA000_0000, "R9 roi bin 0");
    rd(12'h3FC, 32'hA000_003F, "R9 roi bin 63");

    // R10 checksum
    eng_checksum = 8'h5A;
    rd(12'h144, 32'h0000_005A, "R10 checksum");

    // R11 reserved and read-only
    rd(12'h400, 32'h0, "R11 above bin windows");
    rd(12'h030, 32'h0, "R11 reserved parameter gap");
    wr(12'h160, 32'hDEAD_BEEF);
    rd(12'h160, 32'h0, "R11 reserved write ignored");
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, 32'h6FA7_017B, "R11 id not writable");
    wr(12'h140, 32'hFFFF_FFFF);
    rd(12'h140, 32'h0000_0005, "R11 status not writable");
    wr(12'h144, 32'hFFFF_FFFF);
    rd(12'h144, 32'h0000_005A, "R11 checksum word not writable");

    idle(3);
    chk(exp_q.size() == 0, "R2 all reads answered", 32'(exp_q.size()), 32'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule